// File: doc/BRIEF.md
# Single-Product Coin Vending Controller

This block is the control core of a vending machine that sells one product at a fixed price of 15 cents. Customers pay with 5-cent and 10-cent coins. Each accepted coin arrives as a one-cycle pulse on its own input. The controller keeps the running credit in a small state register. It dispenses the product only when the customer presses the vend button while the full price is held. A separate money-back button pays back exactly the credit held, using one of three refund strobes.

Every output is taken from a flip-flop, so the strobes cannot glitch. The cost is that a decision made in one clock cycle shows at the pins one cycle later.

The controller never holds more than the price. Change or excess money is paid back on the refund strobes in the same cycle that the coin is absorbed. When several request pulses arrive together, a fixed priority decides which one is served, and the others are dropped.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is held and after it is released, every output is 0. The credit starts at 0 cents, so a return request right after reset produces no refund.
- R2: With no change due, a nickel adds 5 cents and a dime adds 10 cents to the credit, and the coin produces no output.
- R3: A vend request with 15 cents credited pulses `drop_o` for one cycle and clears the credit to 0.
- R4: A vend request with less than 15 cents credited produces no output and leaves the credit unchanged.
- R5: A return request pulses the one refund strobe that matches the credit: `back5_o` for 5 cents, `back10_o` for 10 cents, `back15_o` for 15 cents, and none for 0 cents. It then clears the credit to 0.
- R6: A dime inserted at 10 cents credit sets the credit to 15 cents and pulses `back5_o` as change.
- R7: At 15 cents credit, a nickel pulses `back5_o` and a dime pulses `back10_o`. The credit stays at 15 cents.
- R8: When several request inputs are high in one cycle, only the highest one acts. The order from highest is return, vend, dime, nickel. The lower inputs have no effect on the outputs or on the credit, even if the winning vend request is itself ignored.
- R9: Outputs are registered. A request sampled at clock edge k shows on the outputs after edge k and not before, and it lasts exactly one cycle.
- R10: At most one of the four outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| coin_dime | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| vend_req | input | 1 | One-cycle pulse: customer asks for the product |
| return_req | input | 1 | One-cycle pulse: customer asks for the money back |
| drop_o | output | 1 | Registered strobe: release one product |
| back5_o | output | 1 | Registered strobe: pay out 5 cents |
| back10_o | output | 1 | Registered strobe: pay out 10 cents |
| back15_o | output | 1 | Registered strobe: pay out 15 cents |

## Verification
A money-back press and a coin, or a vend press and a coin, can arrive in the same cycle. The bench provokes this by raising several request pulses in a single step.

The result is judged in two ways. First, only the winning request's strobe may appear on the next cycle. Second, a money-back press issued afterwards must reveal a credit that the losing coin did not change.

One case needs particular care: a vend press at low credit that still blocks a coin arriving with it. The bench checks that the credit is unchanged afterwards.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Money is counted in coin units of UNIT_CENTS.
    localparam int UNIT_CENTS  = 5;
    localparam int PRICE_UNITS = 3;
    localparam int CREDIT_W    = $clog2(PRICE_UNITS + 1);
    localparam int SUM_W       = CREDIT_W + 1;

    localparam logic [CREDIT_W-1:0] FULL_CODE = CREDIT_W'(PRICE_UNITS);

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'd0,
        CR_5  = 2'd1,
        CR_10 = 2'd2,
        CR_15 = 2'd3
    } credit_e;

    // Single request chosen from the four pulse inputs.
    typedef enum logic [2:0] {
        REQ_IDLE,
        REQ_NICKEL,
        REQ_DIME,
        REQ_VEND,
        REQ_RETURN
    } req_e;

    typedef struct packed {
        logic drop;
        logic back15;
        logic back10;
        logic back5;
    } disp_t;

    localparam int DISP_W = $bits(disp_t);

    // Refund strobe that pays out a given number of units.
    function automatic disp_t refund_units(input logic [SUM_W-1:0] units);
        disp_t d;
        d = '0;
        case (units)
            SUM_W'(1): d.back5  = 1'b1;
            SUM_W'(2): d.back10 = 1'b1;
            SUM_W'(3): d.back15 = 1'b1;
            default:   ;
        endcase
        return d;
    endfunction

    // Value of the coin carried by a request, in units.
    function automatic logic [SUM_W-1:0] coin_units(input req_e r);
        case (r)
            REQ_NICKEL: return SUM_W'(1);
            REQ_DIME:   return SUM_W'(2);
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/vend_req_arb.sv
module vend_req_arb
    import vend_pkg::*;
(
    input  logic nickel,
    input  logic dime,
    input  logic vend,
    input  logic ret,
    output req_e req
);

    // Fixed priority: return, vend, dime, nickel.
    always_comb begin
        if (ret)
            req = REQ_RETURN;
        else if (vend)
            req = REQ_VEND;
        else if (dime)
            req = REQ_DIME;
        else if (nickel)
            req = REQ_NICKEL;
        else
            req = REQ_IDLE;
    end

endmodule

// File: rtl/vend_step_logic.sv
module vend_step_logic
    import vend_pkg::*;
(
    input  credit_e credit,
    input  req_e    req,
    output credit_e credit_nxt,
    output disp_t   disp
);

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] excess;

    assign sum    = {1'b0, credit} + coin_units(req);
    assign excess = sum - SUM_W'(PRICE_UNITS);

    always_comb begin
        credit_nxt = credit;
        disp       = '0;
        case (req)
            REQ_RETURN: begin
                disp       = refund_units({1'b0, credit});
                credit_nxt = CR_0;
            end
            REQ_VEND: begin
                if (credit == credit_e'(FULL_CODE)) begin
                    disp.drop  = 1'b1;
                    credit_nxt = CR_0;
                end
            end
            REQ_NICKEL, REQ_DIME: begin
                if (sum > SUM_W'(PRICE_UNITS)) begin
                    credit_nxt = credit_e'(FULL_CODE);
                    disp       = refund_units(excess);
                end else begin
                    credit_nxt = credit_e'(sum[CREDIT_W-1:0]);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vend_reg.sv
module vend_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_nickel,
    input  logic coin_dime,
    input  logic vend_req,
    input  logic return_req,
    output logic drop_o,
    output logic back5_o,
    output logic back10_o,
    output logic back15_o
);

    req_e                req;
    credit_e             credit_q;
    credit_e             credit_nxt;
    logic [CREDIT_W-1:0] credit_bits;
    disp_t               disp_nxt;
    disp_t               disp_q;

    vend_req_arb u_arb (
        .nickel (coin_nickel),
        .dime   (coin_dime),
        .vend   (vend_req),
        .ret    (return_req),
        .req    (req)
    );

    vend_step_logic u_step (
        .credit     (credit_q),
        .req        (req),
        .credit_nxt (credit_nxt),
        .disp       (disp_nxt)
    );

    vend_reg #(.W(CREDIT_W)) u_credit_reg (
        .clk (clk),
        .rst (rst),
        .d   (credit_nxt),
        .q   (credit_bits)
    );

    assign credit_q = credit_e'(credit_bits);

    // Output stage keeps the strobes glitch free.
    vend_reg #(.W(DISP_W)) u_out_reg (
        .clk (clk),
        .rst (rst),
        .d   (disp_nxt),
        .q   (disp_q)
    );

    assign drop_o   = disp_q.drop;
    assign back5_o  = disp_q.back5;
    assign back10_o = disp_q.back10;
    assign back15_o = disp_q.back15;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic coin_nickel,
    input logic coin_dime,
    input logic vend_req,
    input logic return_req,
    input logic drop_o,
    input logic back5_o,
    input logic back10_o,
    input logic back15_o
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen == 1'b1) begin
            reset_quiet_chk: assert (!(drop_o | back5_o | back10_o | back15_o));
        end
    end

    // R10
    one_output_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drop_o, back5_o, back10_o, back15_o}));

    // R3
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drop_o) |-> $past(vend_req) && !$past(return_req));

    // R3
    drop_once_chk: assert property (@(posedge clk) disable iff (rst)
        drop_o |=> !drop_o);

    // R5
    full_refund_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(back15_o) |-> $past(return_req));

    // R7
    ten_refund_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(back10_o) |-> ($past(return_req) || $past(coin_dime)));

    // R9
    out_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(back5_o) |->
            ($past(return_req) || $past(coin_dime) || $past(coin_nickel)));

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .coin_nickel (coin_nickel),
    .coin_dime   (coin_dime),
    .vend_req    (vend_req),
    .return_req  (return_req),
    .drop_o      (drop_o),
    .back5_o     (back5_o),
    .back10_o    (back10_o),
    .back15_o    (back15_o)
);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;

    localparam time HALF = 2ns;

    // Output codes {drop, back15, back10, back5}
    localparam logic [3:0] O_NONE = 4'b0000;
    localparam logic [3:0] O_DROP = 4'b1000;
    localparam logic [3:0] O_R15  = 4'b0100;
    localparam logic [3:0] O_R10  = 4'b0010;
    localparam logic [3:0] O_R5   = 4'b0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_nickel = 1'b0;
    logic coin_dime = 1'b0;
    logic vend_req = 1'b0;
    logic return_req = 1'b0;
    logic drop_o, back5_o, back10_o, back15_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #HALF clk = ~clk;

    vend_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .coin_nickel (coin_nickel),
        .coin_dime   (coin_dime),
        .vend_req    (vend_req),
        .return_req  (return_req),
        .drop_o      (drop_o),
        .back5_o     (back5_o),
        .back10_o    (back10_o),
        .back15_o    (back15_o)
    );

    function automatic logic [3:0] outs();
        return {drop_o, back15_o, back10_o, back5_o};
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b", tag, got, exp);
        end
    endtask

    // Present inputs for one edge, then sample the registered result.
    task automatic step(input logic n, input logic d, input logic v, input logic r,
                        output logic [3:0] o);
        @(negedge clk);
        coin_nickel = n;
        coin_dime   = d;
        vend_req    = v;
        return_req  = r;
        @(posedge clk);
        #1;
        o = outs();
        coin_nickel = 1'b0;
        coin_dime   = 1'b0;
        vend_req    = 1'b0;
        return_req  = 1'b0;
    endtask

    // Read the credit out through a money-back request.
    task automatic probe(input string tag, input int cents);
        logic [3:0] o;
        logic [3:0] e;
        case (cents)
            5:       e = O_R5;
            10:      e = O_R10;
            15:      e = O_R15;
            default: e = O_NONE;
        endcase
        step(0, 0, 0, 1, o);
        chk(tag, o, e);
    endtask

    task automatic t_reset();
        logic [3:0] o;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 outputs during reset", outs(), O_NONE);
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0, o);
        chk("R1 outputs after reset", o, O_NONE);
        probe("R1 credit zero after reset", 0);
    endtask

    task automatic t_accumulate();
        logic [3:0] o;
        step(1, 0, 0, 0, o);
        chk("R2 nickel silent", o, O_NONE);
        probe("R2 one nickel is 5", 5);
        step(1, 0, 0, 0, o);
        step(1, 0, 0, 0, o);
        chk("R2 second nickel silent", o, O_NONE);
        probe("R2 two nickels are 10", 10);
        step(0, 1, 0, 0, o);
        chk("R2 dime silent", o, O_NONE);
        probe("R2 one dime is 10", 10);
        step(1, 0, 0, 0, o);
        step(0, 1, 0, 0, o);
        chk("R2 nickel plus dime silent", o, O_NONE);
        probe("R5 full credit refunds 15", 15);
        probe("R5 credit cleared by return", 0);
    endtask

    task automatic t_vend();
        logic [3:0] o;
        step(0, 1, 0, 0, o);
        step(1, 0, 0, 0, o);
        step(0, 0, 1, 0, o);
        chk("R3 vend at 15 drops", o, O_DROP);
        step(0, 0, 0, 0, o);
        chk("R9 drop lasts one cycle", o, O_NONE);
        probe("R3 credit cleared by vend", 0);
    endtask

    task automatic t_vend_low();
        logic [3:0] o;
        step(0, 0, 1, 0, o);
        chk("R4 vend at 0 ignored", o, O_NONE);
        step(1, 0, 0, 0, o);
        step(0, 0, 1, 0, o);
        chk("R4 vend at 5 ignored", o, O_NONE);
        probe("R4 credit kept at 5", 5);
    endtask

    task automatic t_change();
        logic [3:0] o;
        step(0, 1, 0, 0, o);
        step(0, 1, 0, 0, o);
        chk("R6 dime at 10 gives 5 change", o, O_R5);
        probe("R6 credit now 15", 15);
    endtask

    task automatic t_overflow();
        logic [3:0] o;
        step(0, 1, 0, 0, o);
        step(1, 0, 0, 0, o);
        step(1, 0, 0, 0, o);
        chk("R7 nickel at 15 refunded", o, O_R5);
        step(0, 1, 0, 0, o);
        chk("R7 dime at 15 refunded", o, O_R10);
        step(0, 0, 1, 0, o);
        chk("R7 credit stayed 15, vend drops", o, O_DROP);
    endtask

    task automatic t_priority();
        logic [3:0] o;
        // credit 15, everything at once: return wins
        step(0, 1, 0, 0, o);
        step(1, 0, 0, 0, o);
        step(1, 1, 1, 1, o);
        chk("R8 return beats all", o, O_R15);
        chk("R10 single strobe", {3'b000, $countones(o) > 1}, 4'b0000);
        probe("R8 credit cleared by return", 0);
        // credit 5, low vend still blocks coins
        step(1, 0, 0, 0, o);
        step(1, 1, 1, 0, o);
        chk("R8 vend at 5 with coins silent", o, O_NONE);
        probe("R8 coins blocked by vend", 5);
        // credit 0, dime beats nickel
        step(1, 1, 0, 0, o);
        chk("R8 dime plus nickel silent", o, O_NONE);
        probe("R8 dime beats nickel", 10);
        // credit 15, vend beats nickel
        step(0, 1, 0, 0, o);
        step(1, 0, 0, 0, o);
        step(1, 0, 1, 0, o);
        chk("R8 vend beats nickel", o, O_DROP);
        probe("R8 credit zero after vend", 0);
        // credit 15, return beats dime
        step(0, 1, 0, 0, o);
        step(1, 0, 0, 0, o);
        step(0, 1, 0, 1, o);
        chk("R8 return beats dime", o, O_R15);
    endtask

    task automatic t_timing();
        logic [3:0] o;
        step(0, 1, 0, 0, o);
        step(1, 0, 0, 0, o);
        @(negedge clk);
        vend_req = 1'b1;
        #1;
        chk("R9 no output before edge", outs(), O_NONE);
        @(posedge clk);
        #1;
        vend_req = 1'b0;
        chk("R9 output after edge", outs(), O_DROP);
        @(posedge clk);
        #1;
        chk("R9 output gone next cycle", outs(), O_NONE);
    endtask

    initial begin
        t_reset();
        t_accumulate();
        t_vend();
        t_vend_low();
        t_change();
        t_overflow();
        t_priority();
        t_timing();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule